// File: doc/BRIEF.md
# Receive Packet Filter and Handler

This block sits behind a byte demodulator and turns a stream of received bytes into whole packets in a receive FIFO. A packet opens with a byte flagged as start-of-packet. It closes with a separate end strobe, and the CRC verdict and the received signal strength arrive with that strobe. The block owns the FIFO write pointer. It drives the write enable, address and data, and it marks each packet with a one-cycle accept or drop pulse.

Two framing modes exist. In fixed mode the configured length is the exact number of bytes in the packet. In variable mode the first byte carries the length, and the configured value is the largest length allowed. An optional address byte can be filtered against a device address, with zero, one or two broadcast values. Two status bytes can follow the payload. A packet that fails its CRC can be removed from the FIFO by restoring the write pointer to where that packet began.

Assumptions: start-of-packet arrives only while the block is idle, and at least two idle cycles pass after an end strobe. The configured length is never zero.

Top module: `rx_pkt_filter`

## Requirements
- R1: During and right after reset, `fifo_we`, `pkt_accept` and `pkt_drop` are low, and the first byte written after reset goes to address 0.
- R2: In fixed mode (`cfg_var_len`=0), the byte flagged by `in_sop` and the bytes after it are written until `cfg_pkt_len` bytes are stored. Further bytes before `in_eop` are not written.
- R3: In variable mode, the byte flagged by `in_sop` is a length L. It is written, and then the next L bytes are written. L includes the address byte when address checking is on.
- R4: In variable mode, L = 0 or L > `cfg_pkt_len` gives a `pkt_drop` pulse and writes nothing for that packet. L = `cfg_pkt_len` is accepted.
- R5: The address byte is the first byte after the length byte (variable mode) or the first byte (fixed mode). `cfg_adr_mode` 0 accepts any address. Mode 1 accepts only `cfg_dev_addr`. Mode 2 also accepts 0x00. Mode 3 also accepts 0x00 and 0xFF.
- R6: A packet whose address fails gives a `pkt_drop` pulse and no further writes. The write pointer returns to the packet's first address, so the next packet starts writing there.
- R7: With `cfg_append_status`=1, two bytes are written in the two cycles after `in_eop`, following the payload. The first is `in_rssi`. The second holds `in_crc_ok` in bit 7, with bits 6:0 zero.
- R8: With `cfg_crc_autoflush`=1 and `in_crc_ok`=0 at `in_eop`, the packet is dropped: no status bytes are written, and the write pointer returns to the packet's first address.
- R9: With `cfg_crc_autoflush`=0, a packet with `in_crc_ok`=0 is still accepted and kept.
- R10: `pkt_accept` is high for exactly one cycle per accepted packet. It rises together with the second status write when status is appended, and otherwise one cycle after the end strobe is sampled. It is never high together with `pkt_drop`.
- R11: An `in_eop` that arrives before all expected bytes are received drops the packet and restores the write pointer.
- R12: Bytes without `in_sop` and end strobes that arrive while idle cause no write and no pulse.
- R13: Successive writes use consecutive addresses, wrapping modulo 2^`FIFO_AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A received byte is present on `in_data` |
| in_sop | input | 1 | The present byte is the first of a packet |
| in_data | input | 8 | Received byte |
| in_eop | input | 1 | End-of-packet strobe, in a cycle without a byte |
| in_crc_ok | input | 1 | CRC verdict, valid with `in_eop` |
| in_rssi | input | 8 | Signal strength, valid with `in_eop` |
| cfg_var_len | input | 1 | 1: length byte leads the packet; 0: fixed length |
| cfg_pkt_len | input | 8 | Fixed length, or maximum length in variable mode |
| cfg_adr_mode | input | 2 | Address filter mode 0..3 |
| cfg_dev_addr | input | 8 | Device address |
| cfg_append_status | input | 1 | Append the two status bytes |
| cfg_crc_autoflush | input | 1 | Discard packets that fail CRC |
| fifo_we | output | 1 | FIFO write enable |
| fifo_waddr | output | FIFO_AW | FIFO write address |
| fifo_wdata | output | 8 | FIFO write data |
| pkt_accept | output | 1 | One-cycle pulse: packet kept |
| pkt_drop | output | 1 | One-cycle pulse: packet discarded |

## Verification
The hardest case to reach from the ports is a rollback after bytes are already in the FIFO. Address rejection, CRC flush and a truncated packet only show their effect when a later packet is written. The bench tracks the address where each kept packet should begin. It then checks that the packet following every dropped one starts at the same place as the dropped one, and that every write in a packet is contiguous. Two 40-byte packets push the pointer across the wrap point of a 64-entry FIFO.

// File: rtl/rx_pkt_pkg.sv
// Shared definitions for the receive packet filter.
// Assumes byte-wide FIFO data.
package rx_pkt_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BODY,
        ST_TAIL,
        ST_STAT2
    } rx_state_e;

    typedef enum logic [1:0] {
        ADR_NONE  = 2'd0,
        ADR_EXACT = 2'd1,
        ADR_BC0   = 2'd2,
        ADR_BC0FF = 2'd3
    } adr_mode_e;

    localparam logic [BYTE_W-1:0] BCAST_LO = 8'h00;
    localparam logic [BYTE_W-1:0] BCAST_HI = 8'hFF;

    // Second status byte: CRC flag in the top bit, link quality field zero.
    function automatic logic [BYTE_W-1:0] crc_status_byte(input logic ok);
        return {ok, {(BYTE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/rx_addr_match.sv
// Address filter: decides whether a received address byte is wanted.
// Purely combinational; the caller presents the address byte when it matters.
module rx_addr_match
    import rx_pkt_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [BYTE_W-1:0] dev_addr,
    input  logic [BYTE_W-1:0] rx_addr,
    output logic              hit
);
    logic own_hit;
    logic lo_hit;
    logic hi_hit;

    // Compare against the device address and the two broadcast values.
    always_comb begin
        own_hit = (rx_addr == dev_addr);
        lo_hit  = (rx_addr == BCAST_LO);
        hi_hit  = (rx_addr == BCAST_HI);
    end

    // Combine the comparisons according to the filter mode.
    always_comb begin
        case (adr_mode_e'(mode))
            ADR_NONE:  hit = 1'b1;
            ADR_EXACT: hit = own_hit;
            ADR_BC0:   hit = own_hit | lo_hit;
            ADR_BC0FF: hit = own_hit | lo_hit | hi_hit;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rx_wptr_ctrl.sv
// FIFO write port with a rollback point.
// mark latches the current pointer as the packet start. restore reloads it.
// Assumes restore and wr_req are never high in the same cycle.
module rx_wptr_ctrl
    import rx_pkt_pkg::*;
#(
    parameter int FIFO_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [BYTE_W-1:0]  wr_byte,
    input  logic               mark,
    input  logic               restore,
    output logic               fifo_we,
    output logic [FIFO_AW-1:0] fifo_waddr,
    output logic [BYTE_W-1:0]  fifo_wdata
);
    localparam logic [FIFO_AW-1:0] PTR_ONE = FIFO_AW'(1);

    logic [FIFO_AW-1:0] wptr_q;
    logic [FIFO_AW-1:0] base_q;

    // Advance, or roll back, the write pointer; remember the packet start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            base_q <= '0;
        end else begin
            if (restore)     wptr_q <= base_q;
            else if (wr_req) wptr_q <= wptr_q + PTR_ONE;
            if (mark)        base_q <= wptr_q;
        end
    end

    // Register the FIFO write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_we    <= 1'b0;
            fifo_waddr <= '0;
            fifo_wdata <= '0;
        end else begin
            fifo_we <= wr_req;
            if (wr_req) begin
                fifo_waddr <= wptr_q;
                fifo_wdata <= wr_byte;
            end
        end
    end

    a_r13_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_we && $past(fifo_we)) |-> (fifo_waddr == $past(fifo_waddr) + PTR_ONE));

    a_r6_rollback_point: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !mark) |=> (wptr_q == $past(base_q)));
endmodule

// File: rtl/rx_pkt_filter.sv
// Receive packet filter and handler.
// Parses the length and address bytes, enforces the length, filters addresses,
// appends status bytes and rolls the FIFO back on a drop.
// Assumes in_sop only while idle, in_eop in a cycle of its own after the last
// byte, and two quiet cycles after in_eop.
module rx_pkt_filter
    import rx_pkt_pkg::*;
#(
    parameter int FIFO_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic [7:0]         in_data,
    input  logic               in_eop,
    input  logic               in_crc_ok,
    input  logic [7:0]         in_rssi,
    input  logic               cfg_var_len,
    input  logic [7:0]         cfg_pkt_len,
    input  logic [1:0]         cfg_adr_mode,
    input  logic [7:0]         cfg_dev_addr,
    input  logic               cfg_append_status,
    input  logic               cfg_crc_autoflush,
    output logic               fifo_we,
    output logic [FIFO_AW-1:0] fifo_waddr,
    output logic [7:0]         fifo_wdata,
    output logic               pkt_accept,
    output logic               pkt_drop
);
    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] remain_q, remain_d;
    logic              crc_q, crc_d;

    logic              adr_hit;
    logic              adr_on;
    logic              len_bad;
    logic              take;
    logic              take_is_adr;
    logic [BYTE_W-1:0] take_cnt;
    logic              wr_req;
    logic [BYTE_W-1:0] wr_byte;
    logic              mark;
    logic              restore;
    logic              acc_ev;
    logic              drop_ev;

    rx_addr_match u_match (
        .mode     (cfg_adr_mode),
        .dev_addr (cfg_dev_addr),
        .rx_addr  (in_data),
        .hit      (adr_hit)
    );

    rx_wptr_ctrl #(.FIFO_AW(FIFO_AW)) u_wptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .wr_byte    (wr_byte),
        .mark       (mark),
        .restore    (restore),
        .fifo_we    (fifo_we),
        .fifo_waddr (fifo_waddr),
        .fifo_wdata (fifo_wdata)
    );

    // Decode the configuration that the state machine needs.
    always_comb begin
        adr_on  = (cfg_adr_mode != 2'd0);
        len_bad = (in_data == '0) || (in_data > cfg_pkt_len);
    end

    // Packet state machine: choose the next state, the writes and the pulses.
    always_comb begin
        state_d     = state_q;
        remain_d    = remain_q;
        crc_d       = crc_q;
        take        = 1'b0;
        take_is_adr = 1'b0;
        take_cnt    = remain_q;
        wr_req      = 1'b0;
        wr_byte     = in_data;
        mark        = 1'b0;
        restore     = 1'b0;
        acc_ev      = 1'b0;
        drop_ev     = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sop) begin
                    mark = 1'b1;
                    if (cfg_var_len) begin
                        if (len_bad) begin
                            drop_ev = 1'b1;
                        end else begin
                            wr_req   = 1'b1;
                            remain_d = in_data;
                            state_d  = adr_on ? ST_ADDR : ST_BODY;
                        end
                    end else begin
                        take        = 1'b1;
                        take_is_adr = adr_on;
                        take_cnt    = cfg_pkt_len;
                    end
                end
            end
            ST_ADDR, ST_BODY: begin
                if (in_eop) begin
                    drop_ev = 1'b1;
                    restore = 1'b1;
                    state_d = ST_IDLE;
                end else if (in_valid) begin
                    take        = 1'b1;
                    take_is_adr = (state_q == ST_ADDR);
                end
            end
            ST_TAIL: begin
                if (in_eop) begin
                    if (cfg_crc_autoflush && !in_crc_ok) begin
                        drop_ev = 1'b1;
                        restore = 1'b1;
                        state_d = ST_IDLE;
                    end else if (cfg_append_status) begin
                        wr_req  = 1'b1;
                        wr_byte = in_rssi;
                        crc_d   = in_crc_ok;
                        state_d = ST_STAT2;
                    end else begin
                        acc_ev  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_STAT2: begin
                wr_req  = 1'b1;
                wr_byte = crc_status_byte(crc_q);
                acc_ev  = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase

        // Store one counted byte, or reject it if it is an unwanted address.
        if (take) begin
            if (take_is_adr && !adr_hit) begin
                drop_ev = 1'b1;
                restore = (state_q != ST_IDLE);
                state_d = ST_IDLE;
            end else begin
                wr_req   = 1'b1;
                wr_byte  = in_data;
                remain_d = take_cnt - 8'd1;
                state_d  = (take_cnt == 8'd1) ? ST_TAIL : ST_BODY;
            end
        end
    end

    // State, byte counter and latched CRC flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            crc_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
            crc_q    <= crc_d;
        end
    end

    // Register the packet verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_accept <= 1'b0;
            pkt_drop   <= 1'b0;
        end else begin
            pkt_accept <= acc_ev;
            pkt_drop   <= drop_ev;
        end
    end

    a_r4_bad_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && in_valid && in_sop && cfg_var_len &&
         (in_data == 8'd0 || in_data > cfg_pkt_len)) |=> (pkt_drop && !fifo_we));

    a_r6_addr_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && in_valid && !in_eop && !adr_hit) |=> (pkt_drop && !fifo_we));

    a_r8_crc_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && in_eop && cfg_crc_autoflush && !in_crc_ok)
        |=> (pkt_drop && !fifo_we));

    a_r7_second_status: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STAT2) |=> (fifo_we && pkt_accept && fifo_wdata[6:0] == 7'd0));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pkt_accept, pkt_drop}));
endmodule

// File: tb/rx_pkt_filter_bench.sv
module rx_pkt_filter_bench;
    localparam int AW   = 6;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, in_crc_ok = 0;
    logic [7:0] in_data = 0, in_rssi = 0;
    logic cfg_var_len = 0, cfg_append_status = 0, cfg_crc_autoflush = 0;
    logic [7:0] cfg_pkt_len = 8'd3, cfg_dev_addr = 8'h12;
    logic [1:0] cfg_adr_mode = 0;
    logic fifo_we, pkt_accept, pkt_drop;
    logic [AW-1:0] fifo_waddr;
    logic [7:0] fifo_wdata;

    always #2.5 clk = ~clk;

    rx_pkt_filter #(.FIFO_AW(AW)) u_rx_pkt_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .in_eop(in_eop), .in_crc_ok(in_crc_ok), .in_rssi(in_rssi),
        .cfg_var_len(cfg_var_len), .cfg_pkt_len(cfg_pkt_len), .cfg_adr_mode(cfg_adr_mode),
        .cfg_dev_addr(cfg_dev_addr), .cfg_append_status(cfg_append_status),
        .cfg_crc_autoflush(cfg_crc_autoflush), .fifo_we(fifo_we), .fifo_waddr(fifo_waddr),
        .fifo_wdata(fifo_wdata), .pkt_accept(pkt_accept), .pkt_drop(pkt_drop)
    );

    int checks = 0, failures = 0;
    int cyc = 0, nw = 0, nacc = 0, ndrop = 0, acc_cyc = 0, last_w_cyc = 0;
    int wa [0:2047];
    int wd [0:2047];
    int s0, a0, d0, exp_ptr = 0;

    // Log the write port and the pulses, away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (fifo_we && nw < 2048) begin
                wa[nw] = int'(fifo_waddr);
                wd[nw] = int'(fifo_wdata);
                nw = nw + 1;
                last_w_cyc = cyc;
            end
            if (pkt_accept) begin nacc = nacc + 1; acc_cyc = cyc; end
            if (pkt_drop) ndrop = ndrop + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic s);
        in_valid = 1; in_data = b; in_sop = s;
        @(posedge clk); #1;
        in_valid = 0; in_sop = 0;
    endtask

    task automatic eop(input logic ok, input logic [7:0] rs);
        in_eop = 1; in_crc_ok = ok; in_rssi = rs;
        @(posedge clk); #1;
        in_eop = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic begin_pkt();
        s0 = nw; a0 = nacc; d0 = ndrop;
    endtask

    // Verdict, write count, start address and contiguity of one packet.
    task automatic expect_pkt(input bit acc, input int exp_n, input string req);
        int n;
        bit contig;
        n = nw - s0;
        chk(n == exp_n, req, "write count", n, exp_n);
        chk((nacc - a0) == (acc ? 1 : 0), req, "accept pulses", nacc - a0, acc ? 1 : 0);
        chk((ndrop - d0) == (acc ? 0 : 1), req, "drop pulses", ndrop - d0, acc ? 0 : 1);
        if (n > 0) begin
            chk(wa[s0] == exp_ptr, req, "start address", wa[s0], exp_ptr);
            contig = 1;
            for (int k = 0; k < n; k++)
                if (wa[s0+k] != ((exp_ptr + k) & MASK)) contig = 0;
            chk(contig, "R13", "contiguous addresses", int'(contig), 1);
            if (acc) exp_ptr = (exp_ptr + n) & MASK;
        end
    endtask

    // Address filter vectors: {mode, device address, received address, kept}.
    localparam logic [18:0] ADR_VEC [12] = '{
        {2'd0, 8'h12, 8'h55, 1'b1},
        {2'd1, 8'h12, 8'h12, 1'b1},
        {2'd1, 8'h12, 8'h13, 1'b0},
        {2'd1, 8'h12, 8'h00, 1'b0},
        {2'd2, 8'h12, 8'h00, 1'b1},
        {2'd2, 8'h12, 8'hFF, 1'b0},
        {2'd2, 8'h12, 8'h12, 1'b1},
        {2'd3, 8'h12, 8'hFF, 1'b1},
        {2'd3, 8'h12, 8'h00, 1'b1},
        {2'd3, 8'h12, 8'h7E, 1'b0},
        {2'd1, 8'hFF, 8'hFF, 1'b1},
        {2'd0, 8'h12, 8'h00, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c;
        repeat (4) @(posedge clk); #1;
        // R1: outputs quiet while in reset
        chk(!fifo_we && !pkt_accept && !pkt_drop, "R1", "outputs in reset",
            {fifo_we, pkt_accept, pkt_drop}, 0);
        rst_n = 1;
        idle(1);
        chk(!fifo_we && !pkt_accept && !pkt_drop, "R1", "outputs after reset",
            {fifo_we, pkt_accept, pkt_drop}, 0);

        // R5 / R6: address filter table in fixed mode, three bytes per packet
        cfg_var_len = 0; cfg_pkt_len = 8'd3;
        for (int i = 0; i < 12; i++) begin
            cfg_adr_mode = ADR_VEC[i][18:17];
            cfg_dev_addr = ADR_VEC[i][16:9];
            begin_pkt();
            put(ADR_VEC[i][8:1], 1);
            put(8'hA0 + 8'(i), 0);
            put(8'hB0 + 8'(i), 0);
            eop(1, 8'h00);
            idle(3);
            if (ADR_VEC[i][0]) begin
                chk(wd[s0] == int'(ADR_VEC[i][8:1]), "R5", "address byte stored",
                    wd[s0], int'(ADR_VEC[i][8:1]));
                expect_pkt(1, 3, "R5");
            end else begin
                expect_pkt(0, 0, "R5");
            end
        end

        // R2: fixed length 4, extra bytes before the end strobe are ignored
        cfg_adr_mode = 0; cfg_pkt_len = 8'd4;
        begin_pkt();
        put(8'h10, 1);
        for (int k = 1; k < 6; k++) put(8'h10 + 8'(k), 0);
        c = cyc;
        eop(1, 8'h00);
        idle(3);
        expect_pkt(1, 4, "R2");
        chk(wd[s0+3] == 8'h13, "R2", "last stored byte", wd[s0+3], 8'h13);
        // R10: accept one cycle after the strobe is sampled
        chk(acc_cyc == c + 2, "R10", "accept timing", acc_cyc, c + 2);

        // R3: variable length, L=3, no address
        cfg_var_len = 1; cfg_pkt_len = 8'd10;
        begin_pkt();
        put(8'd3, 1); put(8'h31, 0); put(8'h32, 0); put(8'h33, 0);
        eop(1, 8'h00); idle(3);
        expect_pkt(1, 4, "R3");
        chk(wd[s0] == 3 && wd[s0+3] == 8'h33, "R3", "length and last byte", wd[s0+3], 8'h33);

        // R4: length 0 and length above maximum are dropped, maximum accepted
        begin_pkt();
        put(8'd0, 1); put(8'h01, 0); eop(1, 8'h00); idle(3);
        expect_pkt(0, 0, "R4");
        begin_pkt();
        put(8'd11, 1); put(8'h01, 0); eop(1, 8'h00); idle(3);
        expect_pkt(0, 0, "R4");
        begin_pkt();
        put(8'd10, 1);
        for (int k = 0; k < 10; k++) put(8'h40 + 8'(k), 0);
        eop(1, 8'h00); idle(3);
        expect_pkt(1, 11, "R4");

        // R6: variable length with address; rejection after the length byte
        cfg_adr_mode = 2'd1; cfg_dev_addr = 8'h21;
        begin_pkt();
        put(8'd3, 1); put(8'h22, 0); put(8'h01, 0); put(8'h02, 0);
        eop(1, 8'h00); idle(3);
        expect_pkt(0, 1, "R6");
        begin_pkt();
        put(8'd3, 1); put(8'h21, 0); put(8'h01, 0); put(8'h02, 0);
        eop(1, 8'h00); idle(3);
        expect_pkt(1, 4, "R6");

        // R7: append status with CRC good
        cfg_adr_mode = 0; cfg_append_status = 1;
        begin_pkt();
        put(8'd2, 1); put(8'hC1, 0); put(8'hC2, 0);
        eop(1, 8'h5A); idle(4);
        expect_pkt(1, 5, "R7");
        chk(wd[s0+3] == 8'h5A, "R7", "signal strength byte", wd[s0+3], 8'h5A);
        chk(wd[s0+4] == 8'h80, "R7", "CRC status byte", wd[s0+4], 8'h80);
        chk(acc_cyc == last_w_cyc, "R10", "accept with last status write", acc_cyc, last_w_cyc);

        // R9: CRC bad, no autoflush, packet is kept
        begin_pkt();
        put(8'd2, 1); put(8'hD1, 0); put(8'hD2, 0);
        eop(0, 8'h33); idle(4);
        expect_pkt(1, 5, "R9");
        chk(wd[s0+4] == 8'h00, "R9", "CRC status byte", wd[s0+4], 8'h00);

        // R8: CRC bad with autoflush, then the next packet reuses the space
        cfg_crc_autoflush = 1;
        begin_pkt();
        put(8'd2, 1); put(8'hE1, 0); put(8'hE2, 0);
        eop(0, 8'h44); idle(4);
        expect_pkt(0, 3, "R8");
        begin_pkt();
        put(8'd1, 1); put(8'hE3, 0);
        eop(1, 8'h45); idle(4);
        expect_pkt(1, 4, "R8");

        // R11: early end strobe in fixed mode
        cfg_var_len = 0; cfg_pkt_len = 8'd5; cfg_append_status = 0; cfg_crc_autoflush = 0;
        begin_pkt();
        put(8'h61, 1); put(8'h62, 0);
        eop(1, 8'h00); idle(3);
        expect_pkt(0, 2, "R11");

        // R12: stray bytes and strobe while idle
        begin_pkt();
        put(8'h77, 0); put(8'h78, 0); eop(1, 8'h00); idle(3);
        chk(nw == s0 && nacc == a0 && ndrop == d0, "R12", "idle activity",
            nw - s0 + nacc - a0 + ndrop - d0, 0);

        // R13: two long packets wrap the 64-entry address space
        cfg_pkt_len = 8'd40;
        for (int p = 0; p < 2; p++) begin
            begin_pkt();
            put(8'h80, 1);
            for (int k = 1; k < 40; k++) put(8'h80 + 8'(k), 0);
            eop(1, 8'h00); idle(3);
            expect_pkt(1, 40, "R13");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule